// File: doc/BRIEF.md
# Pseudo-DMA Handshake Watchdog

This block watches a blind transfer path in which a host moves bytes to a peripheral without polling each handshake. When a transfer is pending and neither the ready handshake completes nor the byte in the holding stage is taken, a programmable down-counter runs out and a sticky timeout flag is raised. The counter advances on a timebase derived by dividing the system clock by 14; it reloads from the programmed value every time a handshake or data move completes.

Software programs the count and an active-low interrupt mask through a count register, and reads or clears the timeout flag through a status/control register. The same control register arms a one-shot interrupt that fires on the next rising edge of the asynchronous DMA request input; that interrupt has no status bit and is removed by disarming. The enabled timeout flag, the DMA-request interrupt and an interrupt from the attached drive are merged onto one registered output line.

Top module: `xfer_watchdog`

## Requirements
- R1: The countdown timebase is one tick every 14 clock cycles; after reset release the first tick takes effect on the 14th rising edge, and then on every 14th edge.
- R2: The count register (select 0) resets to 0xFF and reads back what was last written; bits 6:0 are the timeout count, bit 7 the timeout interrupt mask.
- R3: With a count N loaded and a transfer pending, the timeout flag sets on the (N+1)th tick after the load; N = 0 times out on the first tick.
- R4: The counter does not move while no transfer is pending.
- R5: A completed-handshake pulse reloads the counter from the count register and wins over an expiry on the same edge.
- R6: The timeout flag, read at bit 7 of the status register (select 1, other bits read 0), stays set until cleared, and the counter stops while it is set.
- R7: Any write to the status register clears the flag and reloads the counter, and wins over an expiry on the same edge.
- R8: Count register bit 7 = 0 lets the timeout flag drive the interrupt output; bit 7 = 1 keeps it off the output while the flag still sets.
- R9: Writing status bit 3 = 1 arms the DMA-request interrupt; the next rising edge of the request (after a two-flop synchronizer) asserts the output four edges after the input changes, the interrupt holds while armed, and writing bit 3 = 0 removes it.
- R10: Request edges seen while disarmed are ignored, including a request already high when arming.
- R11: The interrupt output is the registered OR of the enabled timeout flag, the DMA-request interrupt and the drive interrupt input, one edge after its source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_sel | input | 1 | Register select: 0 count, 1 status/control |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Read data of the selected register |
| xfer_busy | input | 1 | A transfer is waiting for its handshake or byte |
| xfer_ack | input | 1 | One-cycle pulse: handshake or byte move completed |
| dma_req | input | 1 | Asynchronous DMA request |
| drive_irq | input | 1 | Interrupt from the attached drive |
| irq_out | output | 1 | Combined registered interrupt |

## Verification
The counter expiry can land on the same edge as a status-register write or a completed-handshake pulse, and the flag must then stay clear. The bench aligns itself to the known tick phase after reset, loads a zero or small count, and schedules the write or the pulse exactly on the expiry edge; it then reads the status register on that edge and again one full countdown later to prove the counter was reloaded rather than stopped.

// File: rtl/wd_pkg.sv
package wd_pkg;
  localparam int unsigned WD_DATA_W = 8;
  localparam int unsigned WD_CNT_W  = 7;
  localparam int unsigned WD_DIV    = 14;

  typedef enum logic {
    SEL_COUNT  = 1'b0,
    SEL_STATUS = 1'b1
  } wd_sel_e;
endpackage

// File: rtl/wd_prescale.sv
module wd_prescale #(
  parameter int unsigned DIV = 14
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0] div_q, div_d;

  always_comb begin
    tick  = (div_q == W'(DIV - 1));
    div_d = tick ? '0 : div_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  a_r1_div_bound: assert property (@(posedge clk) disable iff (!rst_n)
    div_q <= W'(DIV - 1));
endmodule

// File: rtl/wd_timeout.sv
module wd_timeout #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             busy,
  input  logic             ack,
  input  logic             load,
  input  logic             clr,
  input  logic [CNT_W-1:0] load_val,
  output logic             flag
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;
  logic             reload;

  always_comb begin
    reload = load | ack | clr;
    cnt_d  = cnt_q;
    flag_d = flag_q;
    if (clr) flag_d = 1'b0;
    if (reload) begin
      cnt_d = load_val;
    end else if (tick && busy && !flag_q) begin
      if (cnt_q == '0) flag_d = 1'b1;
      else             cnt_d  = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '1;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  a_r3_expiry_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> ($past(tick) && $past(busy) && ($past(cnt_q) == '0)));
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load && !ack && !clr) |=> $stable(cnt_q) && $stable(flag_q));
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (ack || load) |=> (cnt_q == $past(load_val)));
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !flag_q);
endmodule

// File: rtl/wd_req_edge.sv
module wd_req_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic req_async,
  input  logic armed,
  output logic req_irq
);
  logic sync1_q, sync2_q, prev_q, irq_q;
  logic rise, irq_d;

  always_comb begin
    rise  = sync2_q & ~prev_q;
    irq_d = armed ? (irq_q | rise) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      sync1_q <= req_async;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      irq_q   <= irq_d;
    end
  end

  assign req_irq = irq_q;

  a_r10_disarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !irq_q);
  a_r9_hold_while_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && armed) |=> irq_q);
endmodule

// File: rtl/xfer_watchdog.sv
module xfer_watchdog
  import wd_pkg::*;
#(
  parameter int unsigned DATA_W = WD_DATA_W,
  parameter int unsigned CNT_W  = WD_CNT_W,
  parameter int unsigned DIV    = WD_DIV
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              xfer_busy,
  input  logic              xfer_ack,
  input  logic              dma_req,
  input  logic              drive_irq,
  output logic              irq_out
);
  localparam int unsigned MASK_BIT = DATA_W - 1;
  localparam int unsigned FLAG_BIT = DATA_W - 1;
  localparam int unsigned ARM_BIT  = 3;

  logic [DATA_W-1:0] cfg_q, cfg_d;
  logic              arm_q, arm_d;
  logic              irq_q, irq_d;
  logic              cnt_wr, st_wr;
  logic              tick, to_flag, req_irq;
  logic [CNT_W-1:0]  load_val;
  logic              unused_wr_bits;

  always_comb begin
    cnt_wr   = wr_en && (wd_sel_e'(reg_sel) == SEL_COUNT);
    st_wr    = wr_en && (wd_sel_e'(reg_sel) == SEL_STATUS);
    cfg_d    = cnt_wr ? wr_data : cfg_q;
    arm_d    = st_wr ? wr_data[ARM_BIT] : arm_q;
    load_val = cnt_wr ? wr_data[CNT_W-1:0] : cfg_q[CNT_W-1:0];
    irq_d    = (to_flag & ~cfg_q[MASK_BIT]) | req_irq | drive_irq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '1;
      arm_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      arm_q <= arm_d;
      irq_q <= irq_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (wd_sel_e'(reg_sel) == SEL_COUNT) rd_data = cfg_q;
    else                                 rd_data[FLAG_BIT] = to_flag;
  end

  assign irq_out        = irq_q;
  assign unused_wr_bits = ^{wr_data[DATA_W-2:ARM_BIT+1], wr_data[ARM_BIT-1:0]};

  wd_prescale #(.DIV(DIV)) u_prescale (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  wd_timeout #(.CNT_W(CNT_W)) u_timeout (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .busy     (xfer_busy),
    .ack      (xfer_ack),
    .load     (cnt_wr),
    .clr      (st_wr),
    .load_val (load_val),
    .flag     (to_flag)
  );

  wd_req_edge u_req_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_async (dma_req),
    .armed     (arm_q),
    .req_irq   (req_irq)
  );

  a_r11_drive_passes: assert property (@(posedge clk) disable iff (!rst_n)
    drive_irq |=> irq_out);
  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[MASK_BIT] && !req_irq && !drive_irq) |=> !irq_out);
  a_r2_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cfg_q == $past(wr_data)));
endmodule

// File: tb/xfer_watchdog_tb.sv
module xfer_watchdog_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIVN = 14;

  typedef struct {
    bit         is_irq;
    logic [7:0] exp;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       xfer_busy = 1'b0;
  logic       xfer_ack = 1'b0;
  logic       dma_req = 1'b0;
  logic       drive_irq = 1'b0;
  logic       irq_out;

  int    checks = 0;
  int    errors = 0;
  int    ecount = 0;
  bit    done = 1'b0;
  item_t q[$];
  item_t cur;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_watchdog u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .xfer_busy(xfer_busy),
    .xfer_ack(xfer_ack), .dma_req(dma_req), .drive_irq(drive_irq),
    .irq_out(irq_out)
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n) ecount <= 0;
    else        ecount <= ecount + 1;

  // monitor: pops every expected item and compares with the ports
  always @(negedge clk) begin
    while (q.size() > 0) begin
      logic [7:0] act;
      cur = q.pop_front();
      act = cur.is_irq ? {7'b0, irq_out} : rd_data;
      checks++;
      if (act !== cur.exp) begin
        errors++;
        $display("FAIL %s actual %h expected %h", cur.tag, act, cur.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask
  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask
  task automatic goto_edge(input int n);
    while (ecount < n) step();
  endtask
  task automatic to_tick();
    while (ecount % DIVN != 0) step();
  endtask
  task automatic wr(input logic sel, input logic [7:0] d);
    reg_sel = sel; wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask
  task automatic exp_rd(input logic sel, input logic [7:0] e, input string t);
    reg_sel = sel;
    q.push_back('{1'b0, e, t});
  endtask
  task automatic exp_irq(input logic e, input string t);
    q.push_back('{1'b1, {7'b0, e}, t});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int m;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    step();
    // R2 reset state
    exp_rd(1'b0, 8'hFF, "R2 reset count reg");
    exp_irq(1'b0, "R11 reset irq");
    step();
    exp_rd(1'b1, 8'h00, "R6 reset status");
    step();
    wr(1'b0, 8'h5A);
    exp_rd(1'b0, 8'h5A, "R2 readback");
    step();

    // R1 R3: count 3, expiry on 4th tick
    to_tick(); m = ecount;
    wr(1'b0, 8'h03);
    xfer_busy = 1'b1;
    goto_edge(m + DIVN*4 - 1);
    exp_rd(1'b1, 8'h00, "R1 R3 flag before expiry edge");
    step();
    exp_rd(1'b1, 8'h80, "R1 R3 flag on expiry edge");
    exp_irq(1'b0, "R11 output one edge later");
    step();
    exp_irq(1'b1, "R8 enabled timeout drives irq");
    // R6 sticky
    xfer_busy = 1'b0;
    steps(40);
    exp_rd(1'b1, 8'h80, "R6 flag sticky");
    step();
    // R7 clear
    wr(1'b1, 8'h01);
    exp_rd(1'b1, 8'h00, "R7 write clears flag");
    exp_irq(1'b1, "R11 irq drops one edge later");
    step();
    exp_irq(1'b0, "R7 irq cleared");
    // R4 idle: no countdown
    steps(DIVN*6);
    exp_rd(1'b1, 8'h00, "R4 idle keeps counter");
    step();

    // R3 zero count
    to_tick(); m = ecount;
    wr(1'b0, 8'h00);
    xfer_busy = 1'b1;
    goto_edge(m + DIVN - 1);
    exp_rd(1'b1, 8'h00, "R3 zero before first tick");
    step();
    exp_rd(1'b1, 8'h80, "R3 zero expires on first tick");
    xfer_busy = 1'b0;
    step();
    wr(1'b1, 8'h00);
    step();

    // R8 masked
    to_tick(); m = ecount;
    wr(1'b0, 8'h80);
    xfer_busy = 1'b1;
    goto_edge(m + DIVN);
    exp_rd(1'b1, 8'h80, "R8 flag sets while masked");
    steps(2);
    exp_irq(1'b0, "R8 masked irq stays low");
    xfer_busy = 1'b0;
    step();
    wr(1'b1, 8'h00);
    step();

    // R5 periodic acks hold off timeout
    wr(1'b0, 8'h01);
    xfer_busy = 1'b1;
    for (int k = 0; k < 6; k++) begin
      step(); to_tick();
      xfer_ack = 1'b1; step(); xfer_ack = 1'b0;
    end
    exp_rd(1'b1, 8'h00, "R5 acks prevent timeout");
    step();
    // R5 ack on the expiry edge
    xfer_busy = 1'b0;
    to_tick(); m = ecount;
    wr(1'b0, 8'h01);
    xfer_busy = 1'b1;
    goto_edge(m + DIVN*2 - 1);
    xfer_ack = 1'b1; step(); xfer_ack = 1'b0;
    exp_rd(1'b1, 8'h00, "R5 ack wins over expiry");
    goto_edge(m + DIVN*4 - 1);
    exp_rd(1'b1, 8'h00, "R5 reloaded count still running");
    step();
    exp_rd(1'b1, 8'h80, "R5 expiry after full reload");
    xfer_busy = 1'b0;
    step();
    wr(1'b1, 8'h00);
    steps(2);

    // R7 clear on the expiry edge
    to_tick(); m = ecount;
    wr(1'b0, 8'h00);
    xfer_busy = 1'b1;
    goto_edge(m + DIVN - 1);
    wr(1'b1, 8'h00);
    exp_rd(1'b1, 8'h00, "R7 clear wins over expiry");
    goto_edge(m + DIVN*2 - 1);
    step();
    exp_rd(1'b1, 8'h80, "R7 counter reloaded by clear");
    xfer_busy = 1'b0;
    step();
    wr(1'b1, 8'h00);
    steps(3);
    exp_irq(1'b0, "R11 quiet before request tests");

    // R10 disarmed edge ignored
    dma_req = 1'b1;
    steps(6);
    exp_irq(1'b0, "R10 disarmed edge ignored");
    step();
    wr(1'b1, 8'h08);
    steps(5);
    exp_irq(1'b0, "R10 high level at arming ignored");
    step();
    // R9 armed edge
    dma_req = 1'b0;
    steps(4);
    dma_req = 1'b1;
    steps(3);
    exp_irq(1'b0, "R9 before edge reaches output");
    step();
    exp_irq(1'b1, "R9 edge raises irq");
    dma_req = 1'b0;
    steps(5);
    exp_irq(1'b1, "R9 holds while armed");
    step();
    wr(1'b1, 8'h00);
    steps(3);
    exp_irq(1'b0, "R9 disarm removes irq");
    step();

    // R11 drive passthrough
    drive_irq = 1'b1;
    step();
    exp_irq(1'b1, "R11 drive irq passes");
    drive_irq = 1'b0;
    step();
    exp_irq(1'b0, "R11 drive irq released");
    steps(2);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule